// File: doc/BRIEF.md
# Host-to-Coprocessor Command Mailbox

This block is a register-mapped mailbox. A host processor uses it to hand commands to an auxiliary controller core and to collect the results. The host reaches it over a plain 32-bit word bus, with a write strobe, a byte-enable field and a combinational read port. Before the host posts a command, it loads a source pointer, a destination pointer and up to four words of input payload. It then writes the command word. That write raises a one-cycle request toward the coprocessor and sets a busy flag, which the host polls in the status word.

On its own side, the coprocessor sees the latched command, both pointers and the payload words. It fills a four-word result buffer and then strobes completion, with an error flag and an 8-bit error code. Completion clears busy. If the latched command asked for it, completion also raises a one-cycle completion interrupt toward the host.

Every register write must enable all four bytes. The status word repacks the command's sub-ID next to a fixed initiator identity, so its fields are not at the same positions as in the command word.

Top module: `ipc_mailbox`

## Requirements
- R1: After reset, every readable location returns 0, and `h_irq` and `c_irq` are low.
- R2: A full-word host write to offset 0x08 (source pointer), 0x0C (destination pointer) or 0x80+4*i (payload word i, i=0..3) is stored. The stored value reads back at the same offset and appears on `c_sptr`, `c_dptr` or `c_wbuf_data` when `c_wbuf_sel`=i.
- R3: A full-word host write to offset 0x00 while idle is latched onto `c_cmd`, and `c_irq` is high for exactly the next cycle. In the status word, bit 0 (busy) becomes 1, bit 1 (error) and bits [23:16] (code) become 0, bits [7:4] take command bits [15:12], and bits [15:8] take parameter `INIT_ID`.
- R4: A command write while busy is ignored: `c_irq` stays low, and `c_cmd` and the status word are unchanged.
- R5: A `c_done` strobe while busy clears busy and loads `c_done_err` into status bit 1 and `c_done_code` into status bits [23:16]. A `c_done` strobe while idle changes nothing.
- R6: An accepted completion pulses `h_irq` for one cycle when bit 8 of the latched command is 1. It leaves `h_irq` low when that bit is 0.
- R7: A host write with `h_be` other than 4'hF changes no register and starts no command.
- R8: Reads at offset 0x00, at offsets 0x10 to 0x7F and at offsets above 0x9F return 0.
- R9: Only the coprocessor port (`c_rbuf_we`, `c_rbuf_sel`) writes result word i. Host reads return it at 0x90+4*i, and host writes to 0x90..0x9F change nothing.
- R10: When a command write and a completion strobe fall in the same cycle while busy, the completion takes effect and the command is dropped. Busy ends at 0 and `c_irq` stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| h_we | input | 1 | Host write strobe |
| h_addr | input | AW | Host byte address |
| h_be | input | 4 | Host byte enables |
| h_wdata | input | 32 | Host write data |
| h_rdata | output | 32 | Host read data, combinational from h_addr |
| h_irq | output | 1 | Host completion interrupt pulse |
| c_irq | output | 1 | Coprocessor command-posted pulse |
| c_cmd | output | 32 | Latched command word |
| c_sptr | output | 32 | Source pointer |
| c_dptr | output | 32 | Destination pointer |
| c_wbuf_sel | input | 2 | Payload word select |
| c_wbuf_data | output | 32 | Selected payload word |
| c_rbuf_we | input | 1 | Result word write strobe |
| c_rbuf_sel | input | 2 | Result word select |
| c_rbuf_wdata | input | 32 | Result word data |
| c_done | input | 1 | Completion strobe |
| c_done_err | input | 1 | Error flag carried with completion |
| c_done_code | input | 8 | Error code carried with completion |

## Verification
Two functions can fall in the same cycle. A host command write can arrive on the same edge as a coprocessor completion strobe, and the design must let only the completion act. The bench posts a command and then drives a second command word and `c_done` on one cycle. It then checks that busy reads 0, that the error fields came from the strobe, that no second `c_irq` appeared, and that `c_cmd` still holds the first word.

// File: rtl/ipc_mailbox.sv
module ipc_mailbox #(
  parameter int          AW      = 8,
  parameter logic [7:0]  INIT_ID = 8'h5A
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          h_we,
  input  logic [AW-1:0] h_addr,
  input  logic [3:0]    h_be,
  input  logic [31:0]   h_wdata,
  output logic [31:0]   h_rdata,
  output logic          h_irq,
  output logic          c_irq,
  output logic [31:0]   c_cmd,
  output logic [31:0]   c_sptr,
  output logic [31:0]   c_dptr,
  input  logic [1:0]    c_wbuf_sel,
  output logic [31:0]   c_wbuf_data,
  input  logic          c_rbuf_we,
  input  logic [1:0]    c_rbuf_sel,
  input  logic [31:0]   c_rbuf_wdata,
  input  logic          c_done,
  input  logic          c_done_err,
  input  logic [7:0]    c_done_code
);
  localparam int HW = AW - 4;

  logic [31:0]       cmd_q, sptr_q, dptr_q;
  logic [3:0][31:0]  wbuf_q, rbuf_q;
  logic              busy_q, err_q;
  logic [7:0]        code_q, init_q;
  logic [3:0]        sub_q;

  logic full_wr, hit_cmd, hit_sptr, hit_dptr, hit_wbuf, hit_rbuf;
  logic cmd_ok, done_ok;
  logic [31:0] status_w;

  assign full_wr  = h_we && (h_be == 4'hF);
  assign hit_cmd  = h_addr == AW'(8'h00);
  assign hit_sptr = h_addr == AW'(8'h08);
  assign hit_dptr = h_addr == AW'(8'h0C);
  assign hit_wbuf = (h_addr[AW-1:4] == HW'(4'h8)) && (h_addr[1:0] == 2'b00);
  assign hit_rbuf = (h_addr[AW-1:4] == HW'(4'h9)) && (h_addr[1:0] == 2'b00);
  assign done_ok  = c_done && busy_q;
  assign cmd_ok   = full_wr && hit_cmd && !busy_q;
  assign status_w = {8'h00, code_q, init_q, sub_q, 2'b00, err_q, busy_q};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_q  <= '0;
      sptr_q <= '0;
      dptr_q <= '0;
      wbuf_q <= '0;
      rbuf_q <= '0;
      busy_q <= 1'b0;
      err_q  <= 1'b0;
      code_q <= '0;
      init_q <= '0;
      sub_q  <= '0;
      c_irq  <= 1'b0;
      h_irq  <= 1'b0;
    end else begin
      c_irq <= cmd_ok;
      h_irq <= done_ok && cmd_q[8];
      if (full_wr && hit_sptr) sptr_q <= h_wdata;
      if (full_wr && hit_dptr) dptr_q <= h_wdata;
      if (full_wr && hit_wbuf) wbuf_q[h_addr[3:2]] <= h_wdata;
      if (c_rbuf_we) rbuf_q[c_rbuf_sel] <= c_rbuf_wdata;
      if (cmd_ok) begin
        cmd_q  <= h_wdata;
        busy_q <= 1'b1;
        err_q  <= 1'b0;
        code_q <= '0;
        sub_q  <= h_wdata[15:12];
        init_q <= INIT_ID;
      end else if (done_ok) begin
        busy_q <= 1'b0;
        err_q  <= c_done_err;
        code_q <= c_done_code;
      end
    end
  end

  always_comb begin
    h_rdata = '0;
    if (h_addr == AW'(8'h04))  h_rdata = status_w;
    else if (hit_sptr)         h_rdata = sptr_q;
    else if (hit_dptr)         h_rdata = dptr_q;
    else if (hit_wbuf)         h_rdata = wbuf_q[h_addr[3:2]];
    else if (hit_rbuf)         h_rdata = rbuf_q[h_addr[3:2]];
  end

  assign c_cmd       = cmd_q;
  assign c_sptr      = sptr_q;
  assign c_dptr      = dptr_q;
  assign c_wbuf_data = wbuf_q[c_wbuf_sel];

  // R3
  cmd_post_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (h_we && h_be == 4'hF && h_addr == AW'(8'h00) && !busy_q) |=> (c_irq && busy_q));
  // R4
  busy_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && !c_done) |=> (!c_irq && $stable(cmd_q) && busy_q));
  // R5
  done_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (c_done && busy_q) |=> (!busy_q && err_q == $past(c_done_err)));
  // R6
  host_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    h_irq |-> $past(c_done && busy_q && cmd_q[8]));
  // R7
  partial_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (h_we && h_be != 4'hF) |=> ($stable(sptr_q) && $stable(dptr_q) && $stable(wbuf_q) && !c_irq));
  // R9
  rbuf_host_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !c_rbuf_we |=> $stable(rbuf_q));
  // R10
  collide_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (c_done && busy_q && h_we && h_addr == AW'(8'h00)) |=> (!busy_q && !c_irq));
endmodule

// File: tb/test_ipc_mailbox.sv
module test_ipc_mailbox;
  logic clk = 0, rst_n = 0;
  logic h_we = 0;
  logic [7:0] h_addr = 0;
  logic [3:0] h_be = 0;
  logic [31:0] h_wdata = 0, h_rdata;
  logic h_irq, c_irq;
  logic [31:0] c_cmd, c_sptr, c_dptr, c_wbuf_data;
  logic [1:0] c_wbuf_sel = 0, c_rbuf_sel = 0;
  logic c_rbuf_we = 0;
  logic [31:0] c_rbuf_wdata = 0;
  logic c_done = 0, c_done_err = 0;
  logic [7:0] c_done_code = 0;
  int checks = 0, fails = 0;
  logic seen_cirq, seen_hirq;

  always #4 clk = ~clk;

  ipc_mailbox i_ipc_mailbox (.*);

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d, input logic [3:0] be);
    @(negedge clk);
    h_we = 1; h_addr = a; h_wdata = d; h_be = be;
    @(negedge clk);
    seen_cirq = c_irq;
    h_we = 0; h_be = 0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    h_addr = a;
    #1 d = h_rdata;
  endtask

  task automatic done(input logic e, input logic [7:0] code);
    @(negedge clk);
    c_done = 1; c_done_err = e; c_done_code = code;
    @(negedge clk);
    seen_hirq = h_irq;
    c_done = 0;
  endtask

  task automatic t_reset;
    logic [31:0] d;
    rd(8'h04, d); chk("R1 status", d, 0);
    rd(8'h80, d); chk("R1 wbuf", d, 0);
    rd(8'h9C, d); chk("R1 rbuf", d, 0);
    chk("R1 irqs", {h_irq, c_irq}, 0);
  endtask

  task automatic t_regs;
    logic [31:0] d;
    wr(8'h08, 32'h1111_2222, 4'hF);
    wr(8'h0C, 32'h3333_4444, 4'hF);
    for (int i = 0; i < 4; i++) wr(8'h80 + 8'(4*i), 32'hA0 + i, 4'hF);
    rd(8'h08, d); chk("R2 sptr rd", d, 32'h1111_2222);
    rd(8'h0C, d); chk("R2 dptr rd", d, 32'h3333_4444);
    chk("R2 c_sptr", c_sptr, 32'h1111_2222);
    chk("R2 c_dptr", c_dptr, 32'h3333_4444);
    for (int i = 0; i < 4; i++) begin
      rd(8'h80 + 8'(4*i), d); chk("R2 wbuf rd", d, 32'hA0 + i);
      c_wbuf_sel = 2'(i); #1 chk("R2 c_wbuf", c_wbuf_data, 32'hA0 + i);
    end
  endtask

  task automatic t_partial;
    logic [31:0] d;
    wr(8'h08, 32'hDEAD_BEEF, 4'h7);
    rd(8'h08, d); chk("R7 partial sptr", d, 32'h1111_2222);
    wr(8'h00, 32'h0000_0101, 4'hE);
    chk("R7 partial cmd irq", seen_cirq, 0);
    rd(8'h04, d); chk("R7 partial cmd status", d, 0);
  endtask

  task automatic t_cmd;
    logic [31:0] d;
    wr(8'h00, 32'h0010_7142, 4'hF);
    chk("R3 c_irq", seen_cirq, 1);
    @(negedge clk); chk("R3 c_irq one cycle", c_irq, 0);
    chk("R3 c_cmd", c_cmd, 32'h0010_7142);
    rd(8'h04, d); chk("R3 status", d, 32'h0000_5A71);
    wr(8'h00, 32'h0000_9033, 4'hF);
    chk("R4 no irq", seen_cirq, 0);
    chk("R4 c_cmd", c_cmd, 32'h0010_7142);
    rd(8'h04, d); chk("R4 status", d, 32'h0000_5A71);
    done(1, 8'hC3);
    chk("R6 h_irq bit8 set", seen_hirq, 1);
    @(negedge clk); chk("R6 h_irq one cycle", h_irq, 0);
    rd(8'h04, d); chk("R5 status after done", d, 32'h00C3_5A72);
    done(0, 8'h11);
    chk("R5 idle done no irq", seen_hirq, 0);
    rd(8'h04, d); chk("R5 idle done ignored", d, 32'h00C3_5A72);
    wr(8'h00, 32'h0000_3005, 4'hF);
    rd(8'h04, d); chk("R3 error cleared", d, 32'h0000_5A31);
    done(0, 8'h00);
    chk("R6 h_irq bit8 clear", seen_hirq, 0);
    rd(8'h04, d); chk("R5 ok status", d, 32'h0000_5A30);
  endtask

  task automatic t_rbuf;
    logic [31:0] d;
    for (int i = 0; i < 4; i++) begin
      @(negedge clk); c_rbuf_we = 1; c_rbuf_sel = 2'(i); c_rbuf_wdata = 32'hB00 + i;
    end
    @(negedge clk); c_rbuf_we = 0;
    wr(8'h94, 32'hFFFF_FFFF, 4'hF);
    for (int i = 0; i < 4; i++) begin
      rd(8'h90 + 8'(4*i), d); chk("R9 rbuf", d, 32'hB00 + i);
    end
  endtask

  task automatic t_reserved;
    logic [31:0] d;
    wr(8'h40, 32'h1234_5678, 4'hF);
    rd(8'h00, d); chk("R8 cmd reads 0", d, 0);
    rd(8'h40, d); chk("R8 reserved", d, 0);
    rd(8'h10, d); chk("R8 reserved low", d, 0);
    rd(8'hA0, d); chk("R8 above map", d, 0);
  endtask

  task automatic t_collide;
    logic [31:0] d;
    wr(8'h00, 32'h0000_2177, 4'hF);
    @(negedge clk);
    h_we = 1; h_addr = 8'h00; h_wdata = 32'h0000_F0EE; h_be = 4'hF;
    c_done = 1; c_done_err = 1; c_done_code = 8'h5E;
    @(negedge clk);
    seen_cirq = c_irq; seen_hirq = h_irq;
    h_we = 0; h_be = 0; c_done = 0;
    chk("R10 no c_irq", seen_cirq, 0);
    chk("R10 h_irq", seen_hirq, 1);
    chk("R10 c_cmd", c_cmd, 32'h0000_2177);
    rd(8'h04, d); chk("R10 status", d, 32'h005E_5A22);
  endtask

  initial begin
    #2000000;
    fails++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset;
    t_regs;
    t_partial;
    t_cmd;
    t_rbuf;
    t_reserved;
    t_collide;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule